// File: doc/BRIEF.md
# Multi-Bank Streaming FIR Filter

A direct-form FIR filter that accepts one sample per cycle under a valid strobe and emits each result at full precision under its own valid strobe. It keeps several coefficient banks. A per-sample select input chooses which bank that sample's result uses. New coefficients arrive one word per beat on a separate load port and land in a staging (shadow) bank. The staged set becomes live only when a commit strobe is pulsed. This lets software reload a bank without disturbing the filtering already in progress.

Data and coefficient signedness are fixed by parameters. The result width is DATA_W + COEF_W + ceil(log2(TAPS)), so no rounding or overflow can occur. There is one asynchronous active-low reset and one synchronous active-low reset, and either one clears the block.

Top module: `fir_multiset`

## Requirements
- R1: `dout` is OUT_W = DATA_W + COEF_W + $clog2(TAPS) bits and holds the exact sum of products with no truncation. It is unsigned when both DATA_SIGNED and COEF_SIGNED are 0 and two's complement otherwise. Example: 4 taps of data 0x80 times coefficient 0x80 give 65536 signed×signed, 65536 unsigned×unsigned and -65536 signed-data×unsigned-coefficient.
- R2: `dout_vld` pulses exactly once per accepted sample (`din_vld` high at a clock edge), 2 cycles later (LATENCY = 2). With no accepted sample it stays low.
- R3: While `dout_vld` is low, `dout` keeps its previous value.
- R4: Either reset (`arst_n` low at any time, or `rst_n` low at a clock edge) clears `dout` and `dout_vld`, the delay line, every bank, the staging bank and the load index to zero.
- R5: Each `coef_vld` beat writes `coef_in` into the staging bank at tap index 0, 1, … TAPS-1, then wraps back to 0. Staged coefficients have no effect on results until committed.
- R6: A high `set_swap` at a clock edge copies the staging bank into bank `set_sel` and resets the load index. A coefficient beat in that same cycle is written at index 0 of the next fill, and the index then becomes 1.
- R7: `set_sel` is sampled only on an accepted sample. That sample's result uses only the coefficients of that bank.
- R8: A sample accepted in the same cycle as a commit uses the bank's previous contents. The next sample uses the new contents.
- R9: Cycles with `din_vld` low do not shift the delay line, whatever value `din` carries.
- R10: Result tap k multiplies the coefficient at index k by the sample accepted k samples earlier (k = 0 is the newest). DATA_SIGNED and COEF_SIGNED select sign- or zero-extension of each operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arst_n | input | 1 | Asynchronous active-low reset |
| din | input | DATA_W | Input sample |
| din_vld | input | 1 | Sample valid |
| set_sel | input | SEL_W | Bank used by the sample; also the commit target |
| coef_in | input | COEF_W | Coefficient load word |
| coef_vld | input | 1 | Coefficient word valid |
| set_swap | input | 1 | Commit staging bank into bank `set_sel` |
| dout | output | OUT_W | Full-precision result |
| dout_vld | output | 1 | Result valid |

## Verification
Three instances share one stimulus stream: signed×signed, unsigned×unsigned and signed-data×unsigned-coefficient. The bench goes after extreme operands, where a truncated or wrongly extended result would flip sign or lose its top bit. It drives a sample and a commit in the same cycle, where an off-by-one bank update would show the new coefficients one sample early. It commits while a load beat is present, and writes more beats than there are taps, which exposes a misplaced load index. It also alternates the bank per sample and inserts gaps with junk data, where a design that mixes banks or shifts on invalid cycles would produce wrong sums.

// File: rtl/fir_multiset.sv
module fir_multiset #(
  parameter int TAPS = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NSETS = 2,
  parameter bit DATA_SIGNED = 1'b1,
  parameter bit COEF_SIGNED = 1'b1,
  localparam int OUT_W = DATA_W + COEF_W + $clog2(TAPS),
  localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1,
  localparam int PTR_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              din_vld,
  input  logic [SEL_W-1:0]  set_sel,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_vld,
  input  logic              set_swap,
  output logic [OUT_W-1:0]  dout,
  output logic              dout_vld
);
  localparam int PW = DATA_W + COEF_W + 2;
  localparam int LATENCY = 2;

  logic [DATA_W-1:0] hist [TAPS];
  logic [DATA_W-1:0] win [TAPS];
  logic [COEF_W-1:0] shadow [TAPS];
  logic [COEF_W-1:0] bank [NSETS][TAPS];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  wr_idx;
  logic signed [PW-1:0] pnext [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic [OUT_W-1:0]  acc;
  logic              p_vld;

  assign wr_idx = set_swap ? '0 : wr_ptr;

  always_comb begin
    win[0] = din;
    for (int k = 1; k < TAPS; k++) win[k] = hist[k-1];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [DATA_W:0] xe;
    logic signed [COEF_W:0] ce;
    assign xe = {DATA_SIGNED ? win[k][DATA_W-1] : 1'b0, win[k]};
    assign ce = {COEF_SIGNED ? bank[set_sel][k][COEF_W-1] : 1'b0, bank[set_sel][k]};
    assign pnext[k] = xe * ce;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + OUT_W'(prod[k]);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        hist[k] <= '0;
        prod[k] <= '0;
      end
      p_vld    <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        hist[k] <= '0;
        prod[k] <= '0;
      end
      p_vld    <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      p_vld    <= din_vld;
      dout_vld <= p_vld;
      if (p_vld) dout <= acc;
      if (din_vld) begin
        for (int k = 0; k < TAPS; k++) begin
          hist[k] <= win[k];
          prod[k] <= pnext[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int s = 0; s < NSETS; s++)
        for (int k = 0; k < TAPS; k++) bank[s][k] <= '0;
      for (int k = 0; k < TAPS; k++) shadow[k] <= '0;
      wr_ptr <= '0;
    end else if (!rst_n) begin
      for (int s = 0; s < NSETS; s++)
        for (int k = 0; k < TAPS; k++) bank[s][k] <= '0;
      for (int k = 0; k < TAPS; k++) shadow[k] <= '0;
      wr_ptr <= '0;
    end else begin
      if (set_swap)
        for (int k = 0; k < TAPS; k++) bank[set_sel][k] <= shadow[k];
      if (coef_vld) begin
        shadow[wr_idx] <= coef_in;
        wr_ptr <= (wr_idx == PTR_W'(TAPS - 1)) ? '0 : wr_idx + 1'b1;
      end else if (set_swap) begin
        wr_ptr <= '0;
      end
    end
  end
endmodule

// File: rtl/fir_multiset_chk.sv
module fir_multiset_chk #(
  parameter int TAPS = 4,
  parameter int OUT_W = 18,
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arst_n,
  input logic             din_vld,
  input logic             coef_vld,
  input logic             set_swap,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [OUT_W-1:0] dout,
  input logic             dout_vld
);
  logic d1, d2;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      d1 <= 1'b0;
      d2 <= 1'b0;
    end else if (!rst_n) begin
      d1 <= 1'b0;
      d2 <= 1'b0;
    end else begin
      d1 <= din_vld;
      d2 <= d1;
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n || !arst_n)
    dout_vld == d2); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !arst_n)
    !dout_vld |-> $stable(dout)); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_n |=> (!dout_vld && dout == '0)); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !arst_n)
    (coef_vld && !set_swap && wr_ptr == PTR_W'(TAPS - 1)) |=> wr_ptr == '0); // R5
  AST_COMMIT_PTR: assert property (@(posedge clk) disable iff (!rst_n || !arst_n)
    set_swap |=> wr_ptr == PTR_W'($past(coef_vld))); // R6
endmodule

bind fir_multiset fir_multiset_chk #(.TAPS(TAPS), .OUT_W(OUT_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arst_n(arst_n), .din_vld(din_vld), .coef_vld(coef_vld),
  .set_swap(set_swap), .wr_ptr(wr_ptr), .dout(dout), .dout_vld(dout_vld));

// File: tb/fir_multiset_tb.sv
module fir_multiset_tb;
  localparam int TAPS = 4, DW = 8, CW = 8, NS = 2, OUT_W = 18;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, arst_n, din_vld, coef_vld, set_swap;
  logic [DW-1:0] din;
  logic [CW-1:0] coef_in;
  logic [0:0] set_sel;
  logic [OUT_W-1:0] dout_s, dout_u, dout_m;
  logic vld_s, vld_u, vld_m;

  fir_multiset #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .NSETS(NS), .DATA_SIGNED(1), .COEF_SIGNED(1)) u_dut (
    .clk, .rst_n, .arst_n, .din, .din_vld, .set_sel, .coef_in, .coef_vld, .set_swap, .dout(dout_s), .dout_vld(vld_s));
  fir_multiset #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .NSETS(NS), .DATA_SIGNED(0), .COEF_SIGNED(0)) u_dut_u (
    .clk, .rst_n, .arst_n, .din, .din_vld, .set_sel, .coef_in, .coef_vld, .set_swap, .dout(dout_u), .dout_vld(vld_u));
  fir_multiset #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .NSETS(NS), .DATA_SIGNED(1), .COEF_SIGNED(0)) u_dut_m (
    .clk, .rst_n, .arst_n, .din, .din_vld, .set_sel, .coef_in, .coef_vld, .set_swap, .dout(dout_m), .dout_vld(vld_m));

  int total = 0, bad = 0, n_in = 0, n_out = 0;
  bit done = 0;
  string phase = "R4";
  bit ds [3] = '{1, 0, 1};
  bit cs [3] = '{1, 0, 0};

  logic [DW-1:0] m_hist [TAPS];
  logic [CW-1:0] m_sh [TAPS];
  logic [CW-1:0] m_bank [NS][TAPS];
  int m_ptr;
  bit p_vld, e_vld;
  longint p_val [3], e_val [3];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint ext(logic [7:0] v, bit s);
    return s ? longint'($signed(v)) : longint'(v);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < TAPS; k++) begin
      m_hist[k] = '0; m_sh[k] = '0;
      for (int s = 0; s < NS; s++) m_bank[s][k] = '0;
    end
    m_ptr = 0; p_vld = 0; e_vld = 0;
    for (int c = 0; c < 3; c++) begin p_val[c] = 0; e_val[c] = 0; end
  endtask

  task automatic model_edge();
    logic [DW-1:0] w [TAPS];
    int idx;
    if (!rst_n || !arst_n) begin model_reset(); return; end
    e_vld = p_vld;
    if (p_vld) for (int c = 0; c < 3; c++) e_val[c] = p_val[c];
    if (p_vld) n_out++;
    p_vld = din_vld;
    if (din_vld) begin
      n_in++;
      w[0] = din;
      for (int k = 1; k < TAPS; k++) w[k] = m_hist[k-1];
      for (int c = 0; c < 3; c++) begin
        p_val[c] = 0;
        for (int k = 0; k < TAPS; k++) p_val[c] += ext(w[k], ds[c]) * ext(m_bank[set_sel][k], cs[c]);
      end
      for (int k = 0; k < TAPS; k++) m_hist[k] = w[k];
    end
    if (set_swap) for (int k = 0; k < TAPS; k++) m_bank[set_sel][k] = m_sh[k];
    idx = set_swap ? 0 : m_ptr;
    if (coef_vld) begin
      m_sh[idx] = coef_in;
      m_ptr = (idx == TAPS - 1) ? 0 : idx + 1;
    end else if (set_swap) m_ptr = 0;
  endtask

  task automatic compare();
    chk(vld_s == e_vld && vld_u == e_vld && vld_m == e_vld, phase, vld_s, e_vld);
    chk(dout_s == e_val[0][OUT_W-1:0], phase, dout_s, e_val[0][OUT_W-1:0]);
    chk(dout_u == e_val[1][OUT_W-1:0], phase, dout_u, e_val[1][OUT_W-1:0]);
    chk(dout_m == e_val[2][OUT_W-1:0], phase, dout_m, e_val[2][OUT_W-1:0]);
  endtask

  task automatic step(bit dv, logic [DW-1:0] d, bit sel, bit cv, logic [CW-1:0] c, bit sw);
    din_vld = dv; din = d; set_sel = sel; coef_vld = cv; coef_in = c; set_swap = sw;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic load(int n);
    for (int i = 0; i < n; i++) step(0, 8'($urandom), 0, 1, 8'($urandom), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; arst_n = 0;
    din_vld = 0; din = '0; set_sel = '0; coef_vld = 0; coef_in = '0; set_swap = 0;
    model_reset();
    #5;
    chk(dout_s == '0 && vld_s == 0, "R4", dout_s, 0);
    @(negedge clk); arst_n = 1;
    phase = "R4";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    rst_n = 1;
    phase = "R5";
    load(4);
    for (int i = 0; i < 6; i++) step(1, 8'($urandom), 0, 0, 0, 0);
    phase = "R6";
    step(0, 0, 0, 0, 0, 1);
    phase = "R10";
    for (int i = 0; i < 10; i++) step(1, 8'($urandom), 0, 0, 0, 0);
    phase = "R5";
    load(6);
    phase = "R6";
    step(0, 0, 1, 1, 8'h5A, 1);
    load(3);
    step(0, 0, 1, 0, 0, 1);
    phase = "R7";
    for (int i = 0; i < 16; i++) step(1, 8'($urandom), 1'($urandom), 0, 0, 0);
    phase = "R8";
    load(4);
    step(1, 8'($urandom), 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 8'($urandom), 0, 0, 0, 0);
    phase = "R3/R9";
    for (int i = 0; i < 30; i++) step(1'($urandom), 8'($urandom), 1'($urandom), 0, 0, 0);
    phase = "R1";
    for (int i = 0; i < TAPS; i++) step(0, 0, 0, 1, 8'h80, 0);
    step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < TAPS; i++) step(1, 8'h80, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk($signed(dout_s) == 65536, "R1", $signed(dout_s), 65536);
    chk(dout_u == 65536, "R1", dout_u, 65536);
    chk($signed(dout_m) == -65536, "R1", $signed(dout_m), -65536);
    step(0, 0, 0, 0, 0, 0);
    chk(n_in == n_out, "R2", n_out, n_in);
    phase = "R4";
    step(1, 8'h33, 0, 0, 0, 0);
    arst_n = 0;
    #1;
    chk(dout_s == '0 && vld_s == 0 && dout_u == '0 && vld_m == 0, "R4", dout_s, 0);
    model_reset();
    step(0, 0, 0, 0, 0, 0);
    arst_n = 1;
    phase = "R2";
    for (int i = 0; i < 8; i++) step(1'($urandom), 8'($urandom), 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule